// File: doc/BRIEF.md
# Width-Selectable ALU with Per-Flag Write Enables

This block is the combinational arithmetic and logic unit of an 8/16-bit accumulator-style processor core. A single width-select input switches it between 8-bit and 16-bit operation. For each opcode it produces a 16-bit result and fresh Negative, Overflow, Zero and Carry values. Beside each flag value it raises a write-enable, so the status register in the core updates only the flags that the operation owns.

The operations are:
- add and subtract with carry
- the three bitwise logic functions
- compare
- test-and-set bits and test-and-reset bits
- the bit test, with memory and immediate flavours
- shifts and rotates through carry
- increment and decrement
- exchange of the two bytes of a 16-bit value

Operand A is the register side (accumulator or index register). Operand B is the memory or immediate side. Every operation has single-cycle combinational timing. Decimal arithmetic and register storage sit outside this block.

Top module: `wide_alu`

## Requirements
- R1: Opcode 0 (add) gives A + B + carryIn at the active width. C is the carry out of the top active bit. V is signed overflow. N is the top active result bit, and Z is set when the active result is zero. N, V, Z and C are all written.
- R2: Opcode 1 (subtract) gives A - B - (1 - carryIn) at the active width. C = 1 means no borrow. V is signed overflow. N and Z come from the result. N, V, Z and C are written.
- R3: Opcodes 2, 3 and 4 give A AND B, A OR B and A XOR B. They write only N and Z, taken from the result.
- R4: Opcode 5 returns B OR A, and opcode 6 returns B AND NOT A. Both write only Z, which is set when A AND B is zero at the active width.
- R5: Opcode 7 (bit test) returns A unchanged, and Z is set when A AND B is zero. With immMode = 0 it also writes N and V, copied from the top and next-to-top active bits of B. With immMode = 1 it writes only Z.
- R6: The shift and rotate opcodes are 8 (shift left), 9 (shift right), 10 (rotate left) and 11 (rotate right). Shifts fill the vacated end with 0, and rotates fill it with carryIn. C receives the bit shifted out. N, Z and C are written.
- R7: Opcode 12 (compare) returns A unchanged. C is set when A >= B unsigned. N and Z come from A - B at the active width. Only N, Z and C are written.
- R8: Opcodes 13 and 14 give A + 1 and A - 1, wrapping at the active width. Only N and Z are written.
- R9: Opcode 15 returns the full 16-bit A with its bytes exchanged, whatever the width select. N and Z come from the new low byte, and only N and Z are written.
- R10: With wideMode = 0, every flag is taken at bit 7 and over the low byte. Result bits 15:8 equal A bits 15:8 for every opcode except 15.
- R11: A flag output whose write enable is low is driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 4 | Operation select, encoded as listed in the requirements |
| wideMode | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| immMode | input | 1 | Operand B is an immediate value (affects the bit test only) |
| opA | input | 16 | Register-side operand |
| opB | input | 16 | Memory- or immediate-side operand |
| carryIn | input | 1 | Current carry flag |
| result | output | 16 | Operation result |
| nOut | output | 1 | New Negative value |
| vOut | output | 1 | New Overflow value |
| zOut | output | 1 | New Zero value |
| cOut | output | 1 | New Carry value |
| weN | output | 1 | Write enable for Negative |
| weV | output | 1 | Write enable for Overflow |
| weZ | output | 1 | Write enable for Zero |
| weC | output | 1 | Write enable for Carry |

## Verification
The bench builds the block with its default 16-bit data width, so the narrow mode is exactly the 8-bit half. Both widths can then be driven through the same ports. Directed vectors hit the carry and overflow boundaries at bit 7 and at bit 15, plus the operand values 0x00FF, 0x7F and 0x8000. Within one run they show that narrow-mode flags ignore the upper byte, while the upper byte of A still passes through to the result. A long stream of random vectors across all sixteen opcodes, both widths and both immediate settings completes the coverage.

// File: rtl/wide_alu_pkg.sv
package wide_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_SETB  = 4'd5,
    OP_CLRB  = 4'd6,
    OP_BITT  = 4'd7,
    OP_SHL   = 4'd8,
    OP_SHR   = 4'd9,
    OP_ROL   = 4'd10,
    OP_ROR   = 4'd11,
    OP_CMP   = 4'd12,
    OP_INC   = 4'd13,
    OP_DEC   = 4'd14,
    OP_SWAP  = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    SEL_SUM,
    SEL_LOGIC,
    SEL_SHIFT,
    SEL_STEP,
    SEL_SWAP,
    SEL_PASS
  } res_sel_e;

  typedef enum logic [1:0] {
    LOG_AND,
    LOG_OR,
    LOG_XOR,
    LOG_CLR
  } log_sel_e;

  typedef struct packed {
    res_sel_e resSel;
    log_sel_e logicSel;
    logic     invertB;
    logic     forceCarry;
    logic     shiftRight;
    logic     rotate;
    logic     stepDown;
    logic     nzFromSum;
    logic     zFromMask;
    logic     nvFromOperand;
    logic     weN;
    logic     weV;
    logic     weZ;
    logic     weC;
  } alu_ctrl_t;

endpackage

// File: rtl/wide_alu_ctrl.sv
module wide_alu_ctrl
  import wide_alu_pkg::*;
(
  input  logic [3:0] opcode,
  input  logic       immMode,
  output alu_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.resSel   = SEL_PASS;
    ctrl.logicSel = LOG_AND;
    unique case (alu_op_e'(opcode))
      OP_ADD: begin
        ctrl.resSel = SEL_SUM;
        {ctrl.weN, ctrl.weV, ctrl.weZ, ctrl.weC} = 4'b1111;
      end
      OP_SUB: begin
        ctrl.resSel  = SEL_SUM;
        ctrl.invertB = 1'b1;
        {ctrl.weN, ctrl.weV, ctrl.weZ, ctrl.weC} = 4'b1111;
      end
      OP_AND, OP_OR, OP_XOR: begin
        ctrl.resSel   = SEL_LOGIC;
        ctrl.logicSel = (opcode == OP_AND) ? LOG_AND :
                        (opcode == OP_OR)  ? LOG_OR  : LOG_XOR;
        ctrl.weN = 1'b1;
        ctrl.weZ = 1'b1;
      end
      OP_SETB, OP_CLRB: begin
        ctrl.resSel    = SEL_LOGIC;
        ctrl.logicSel  = (opcode == OP_SETB) ? LOG_OR : LOG_CLR;
        ctrl.zFromMask = 1'b1;
        ctrl.weZ       = 1'b1;
      end
      OP_BITT: begin
        ctrl.resSel        = SEL_PASS;
        ctrl.zFromMask     = 1'b1;
        ctrl.nvFromOperand = ~immMode;
        ctrl.weZ           = 1'b1;
        ctrl.weN           = ~immMode;
        ctrl.weV           = ~immMode;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        ctrl.resSel     = SEL_SHIFT;
        ctrl.shiftRight = (opcode == OP_SHR) || (opcode == OP_ROR);
        ctrl.rotate     = (opcode == OP_ROL) || (opcode == OP_ROR);
        {ctrl.weN, ctrl.weZ, ctrl.weC} = 3'b111;
      end
      OP_CMP: begin
        ctrl.resSel     = SEL_PASS;
        ctrl.invertB    = 1'b1;
        ctrl.forceCarry = 1'b1;
        ctrl.nzFromSum  = 1'b1;
        {ctrl.weN, ctrl.weZ, ctrl.weC} = 3'b111;
      end
      OP_INC, OP_DEC: begin
        ctrl.resSel   = SEL_STEP;
        ctrl.stepDown = (opcode == OP_DEC);
        ctrl.weN = 1'b1;
        ctrl.weZ = 1'b1;
      end
      OP_SWAP: begin
        ctrl.resSel = SEL_SWAP;
        ctrl.weN = 1'b1;
        ctrl.weZ = 1'b1;
      end
      default: ;
    endcase
  end

  // Bitwise logic never claims V or C
  always_comb begin
    if (!$isunknown(opcode) && ctrl.resSel == SEL_LOGIC)
      assert_logic_no_vc_R3: assert (!ctrl.weV && !ctrl.weC)
        else $error("logic op enables V or C");
  end

  // Immediate bit test: only Z
  always_comb begin
    if (!$isunknown({opcode, immMode}) && opcode == OP_BITT && immMode)
      assert_bit_imm_z_only_R5: assert (ctrl.weZ && !ctrl.weN && !ctrl.weV && !ctrl.weC)
        else $error("immediate bit test writes more than Z");
  end

endmodule

// File: rtl/wide_alu_path.sv
module wide_alu_path
  import wide_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_ctrl_t         ctrl,
  input  logic              wideMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              nOut,
  output logic              vOut,
  output logic              zOut,
  output logic              cOut
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] actMask, topMask;
  logic [DATA_W-1:0] aAct, bAct, bAdd;
  logic [DATA_W:0]   sumExt;
  logic [DATA_W-1:0] sumAct, logicVal, shiftVal, stepVal, swapVal, coreVal, nzVal;
  logic              cinAdd, sumCarry, sumOvf, shiftOut, insertBit;
  logic              nRaw, vRaw, zRaw, cRaw;

  function automatic logic topBit(input logic [DATA_W-1:0] v, input logic wide);
    return wide ? v[DATA_W-1] : v[HALF_W-1];
  endfunction

  function automatic logic nextBit(input logic [DATA_W-1:0] v, input logic wide);
    return wide ? v[DATA_W-2] : v[HALF_W-2];
  endfunction

  assign actMask = wideMode ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  assign topMask = wideMode ? {1'b1, {(DATA_W-1){1'b0}}}
                            : {{HALF_W{1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};
  assign aAct = opA & actMask;
  assign bAct = opB & actMask;

  // Adder shared by add, subtract and compare
  assign bAdd     = (ctrl.invertB ? ~opB : opB) & actMask;
  assign cinAdd   = ctrl.forceCarry | carryIn;
  assign sumExt   = {1'b0, aAct} + {1'b0, bAdd} + {{DATA_W{1'b0}}, cinAdd};
  assign sumAct   = sumExt[DATA_W-1:0] & actMask;
  assign sumCarry = wideMode ? sumExt[DATA_W] : sumExt[HALF_W];
  assign sumOvf   = topBit(~(aAct ^ bAdd) & (aAct ^ sumAct), wideMode);

  always_comb begin
    unique case (ctrl.logicSel)
      LOG_AND: logicVal = aAct & bAct;
      LOG_OR:  logicVal = aAct | bAct;
      LOG_XOR: logicVal = aAct ^ bAct;
      default: logicVal = bAct & ~aAct;
    endcase
  end

  // Shift and rotate unit
  assign insertBit = ctrl.rotate & carryIn;
  always_comb begin
    if (ctrl.shiftRight) begin
      shiftVal = (aAct >> 1) | (insertBit ? topMask : '0);
      shiftOut = aAct[0];
    end else begin
      shiftVal = ((aAct << 1) | {{(DATA_W-1){1'b0}}, insertBit}) & actMask;
      shiftOut = topBit(aAct, wideMode);
    end
  end

  assign stepVal = (aAct + (ctrl.stepDown ? actMask : {{(DATA_W-1){1'b0}}, 1'b1})) & actMask;
  assign swapVal = {opA[HALF_W-1:0], opA[DATA_W-1:HALF_W]};

  always_comb begin
    unique case (ctrl.resSel)
      SEL_SUM:   coreVal = sumAct;
      SEL_LOGIC: coreVal = logicVal;
      SEL_SHIFT: coreVal = shiftVal;
      SEL_STEP:  coreVal = stepVal;
      SEL_SWAP:  coreVal = swapVal;
      default:   coreVal = aAct;
    endcase
  end

  always_comb begin
    if (ctrl.resSel == SEL_SWAP)
      result = swapVal;
    else if (wideMode)
      result = coreVal;
    else
      result = {opA[DATA_W-1:HALF_W], coreVal[HALF_W-1:0]};
  end

  // Flag sources
  assign nzVal = ctrl.nzFromSum ? sumAct : coreVal;

  always_comb begin
    if (ctrl.resSel == SEL_SWAP) begin
      nRaw = swapVal[HALF_W-1];
      zRaw = ~|swapVal[HALF_W-1:0];
    end else begin
      nRaw = ctrl.nvFromOperand ? topBit(bAct, wideMode) : topBit(nzVal, wideMode);
      zRaw = ctrl.zFromMask ? ~|(aAct & bAct) : ~|(nzVal & actMask);
    end
    vRaw = ctrl.nvFromOperand ? nextBit(bAct, wideMode) : sumOvf;
    cRaw = (ctrl.resSel == SEL_SHIFT) ? shiftOut : sumCarry;
  end

  assign nOut = ctrl.weN & nRaw;
  assign vOut = ctrl.weV & vRaw;
  assign zOut = ctrl.weZ & zRaw;
  assign cOut = ctrl.weC & cRaw;

  // Compare carry agrees with an independent magnitude comparison
  always_comb begin
    if (!$isunknown({opA, opB, wideMode}) && ctrl.nzFromSum && ctrl.weC)
      assert_cmp_carry_R7: assert (cOut == (aAct >= bAct))
        else $error("compare carry disagrees with magnitude");
  end

  // Narrow mode keeps the upper byte of A
  always_comb begin
    if (!$isunknown({opA, wideMode}) && !wideMode && ctrl.resSel != SEL_SWAP)
      assert_narrow_upper_R10: assert (result[DATA_W-1:HALF_W] == opA[DATA_W-1:HALF_W])
        else $error("narrow mode altered upper byte");
  end

endmodule

// File: rtl/wide_alu.sv
module wide_alu
  import wide_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        opcode,
  input  logic              wideMode,
  input  logic              immMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              nOut,
  output logic              vOut,
  output logic              zOut,
  output logic              cOut,
  output logic              weN,
  output logic              weV,
  output logic              weZ,
  output logic              weC
);

  localparam int HALF_W = DATA_W / 2;

  alu_ctrl_t ctrl;

  wide_alu_ctrl ctrl_i (
    .opcode (opcode),
    .immMode(immMode),
    .ctrl   (ctrl)
  );

  wide_alu_path #(.DATA_W(DATA_W)) path_i (
    .ctrl    (ctrl),
    .wideMode(wideMode),
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .result  (result),
    .nOut    (nOut),
    .vOut    (vOut),
    .zOut    (zOut),
    .cOut    (cOut)
  );

  assign weN = ctrl.weN;
  assign weV = ctrl.weV;
  assign weZ = ctrl.weZ;
  assign weC = ctrl.weC;

  // Byte swap flags track the high byte of A (the new low byte)
  always_comb begin
    if (!$isunknown({opcode, opA}) && opcode == OP_SWAP)
      assert_swap_flags_R9: assert (zOut == (opA[DATA_W-1:HALF_W] == '0) && nOut == opA[DATA_W-1])
        else $error("swap flags not from new low byte");
  end

  // Disabled flags read as zero
  always_comb begin
    if (!$isunknown({opcode, immMode, opA, opB, carryIn, wideMode}))
      assert_quiet_flags_R11: assert ((weN | !nOut) && (weV | !vOut) && (weZ | !zOut) && (weC | !cOut))
        else $error("disabled flag driven high");
  end

endmodule

// File: tb/wide_alu_tb_top.sv
module wide_alu_tb_top;

  logic        clk = 1'b0;
  logic [3:0]  opcode = '0;
  logic        wideMode = 1'b0, immMode = 1'b0, carryIn = 1'b0;
  logic [15:0] opA = '0, opB = '0, result;
  logic        nOut, vOut, zOut, cOut, weN, weV, weZ, weC;

  int vecCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wide_alu dut_i (
    .opcode(opcode), .wideMode(wideMode), .immMode(immMode),
    .opA(opA), .opB(opB), .carryIn(carryIn), .result(result),
    .nOut(nOut), .vOut(vOut), .zOut(zOut), .cOut(cOut),
    .weN(weN), .weV(weV), .weZ(weZ), .weC(weC)
  );

  function automatic string reqOf(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2, 3, 4: return "R3";
      5, 6: return "R4";
      7: return "R5";
      8, 9, 10, 11: return "R6";
      12: return "R7";
      13, 14: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic applyVec(input int op, input bit wd, input bit im,
                          input int a16, input int b16, input bit ci);
    int w, m, tb, a, b, s, r, full;
    bit n, v, z, c;
    bit [3:0] en;
    bit [7:0] fl, got;
    w = wd ? 16 : 8;
    m = (1 << w) - 1;
    tb = 1 << (w - 1);
    a = a16 & m;
    b = b16 & m;
    n = 0; v = 0; z = 0; c = 0; r = a; en = 4'b0000;
    case (op)
      0: begin s = a + b + ci; r = s & m; c = ((s >> w) & 1) != 0;
               v = ((~(a ^ b)) & (a ^ r) & tb) != 0; en = 4'b1111; end
      1: begin s = a + ((~b) & m) + ci; r = s & m; c = ((s >> w) & 1) != 0;
               v = (((a ^ b) & (a ^ r)) & tb) != 0; en = 4'b1111; end
      2: begin r = a & b; en = 4'b1010; end
      3: begin r = a | b; en = 4'b1010; end
      4: begin r = a ^ b; en = 4'b1010; end
      5: begin r = b | a; en = 4'b0010; end
      6: begin r = b & ~a & m; en = 4'b0010; end
      7: begin r = a; en = im ? 4'b0010 : 4'b1110;
               n = (b & tb) != 0; v = (b & (tb >> 1)) != 0; end
      8: begin c = (a & tb) != 0; r = (a << 1) & m; en = 4'b1011; end
      9: begin c = (a & 1) != 0; r = a >> 1; en = 4'b1011; end
      10: begin c = (a & tb) != 0; r = ((a << 1) | int'(ci)) & m; en = 4'b1011; end
      11: begin c = (a & 1) != 0; r = (a >> 1) | (ci ? tb : 0); en = 4'b1011; end
      12: begin s = (a - b) & m; n = (s & tb) != 0; z = (s == 0); c = (a >= b);
                r = a; en = 4'b1011; end
      13: begin r = (a + 1) & m; en = 4'b1010; end
      14: begin r = (a + m) & m; en = 4'b1010; end
      default: en = 4'b1010;
    endcase
    if (op == 15) begin
      full = ((a16 & 'hFF) << 8) | ((a16 >> 8) & 'hFF);
      n = (a16 & 'h8000) != 0;
      z = ((a16 >> 8) & 'hFF) == 0;
    end else begin
      full = wd ? r : ((a16 & 'hFF00) | (r & 'hFF));
      if (op != 7 && op != 12) n = (r & tb) != 0;
      if (op == 5 || op == 6 || op == 7) z = (a & b) == 0;
      else if (op != 12) z = (r == 0);
    end
    n &= en[3]; v &= en[2]; z &= en[1]; c &= en[0];

    @(posedge clk);
    #1;
    opcode = 4'(op); wideMode = wd; immMode = im;
    opA = 16'(a16); opB = 16'(b16); carryIn = ci;
    @(negedge clk);
    vecCount++;
    fl  = {en, n, v, z, c};
    got = {weN, weV, weZ, weC, nOut, vOut, zOut, cOut};
    if (result !== 16'(full) || got !== fl) begin
      failCount++;
      $display("FAIL %s op=%0d wide=%0b imm=%0b a=%h b=%h ci=%0b: result=%h en/nvzc=%b expected result=%h en/nvzc=%b",
               reqOf(op), op, wd, im, a16[15:0], b16[15:0], ci, result, got, 16'(full), fl);
    end
    // R11: a flag with its enable low must read 0
    vecCount++;
    if (((~{weN, weV, weZ, weC}) & {nOut, vOut, zOut, cOut}) != 4'b0) begin
      failCount++;
      $display("FAIL R11 op=%0d: flags=%b enables=%b expected no flag outside enables",
               op, {nOut, vOut, zOut, cOut}, {weN, weV, weZ, weC});
    end
    // R10: narrow mode keeps A's upper byte
    if (!wd && op != 15) begin
      vecCount++;
      if (result[15:8] !== 8'(a16 >> 8)) begin
        failCount++;
        $display("FAIL R10 op=%0d: upper=%h expected %h", op, result[15:8], 8'(a16 >> 8));
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog expired: ran=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    // R1 carry and overflow at bit 7 and bit 15
    applyVec(0, 0, 0, 'h7F, 'h01, 0);
    applyVec(0, 0, 0, 'hAAFF, 'h01, 0);
    applyVec(0, 1, 0, 'h7FFF, 'h0001, 0);
    applyVec(0, 1, 0, 'hFFFF, 'h0000, 1);
    applyVec(0, 1, 0, 'h00FF, 'h0001, 0);
    // R2 borrow and overflow
    applyVec(1, 0, 0, 'h80, 'h01, 1);
    applyVec(1, 0, 0, 'h00, 'h01, 1);
    applyVec(1, 1, 0, 'h8000, 'h0001, 1);
    applyVec(1, 1, 0, 'h0005, 'h0005, 0);
    // R3 logic
    applyVec(2, 1, 0, 'hF0F0, 'h0FF0, 0);
    applyVec(3, 0, 0, 'h1200, 'h0080, 0);
    applyVec(4, 0, 0, 'h55, 'h55, 1);
    // R4 set / clear bits
    applyVec(5, 0, 0, 'h0F, 'hF0, 0);
    applyVec(6, 1, 0, 'h00FF, 'h0FFF, 0);
    // R5 bit test memory and immediate
    applyVec(7, 0, 0, 'h01, 'hC0, 0);
    applyVec(7, 0, 1, 'h01, 'hC0, 0);
    applyVec(7, 1, 0, 'h0100, 'h4100, 0);
    // R6 shifts and rotates
    applyVec(8, 0, 0, 'h1280, 0, 0);
    applyVec(9, 1, 0, 'h0001, 0, 1);
    applyVec(10, 0, 0, 'h40, 0, 1);
    applyVec(11, 0, 0, 'h01, 0, 1);
    applyVec(11, 1, 0, 'h0002, 0, 1);
    // R7 compare
    applyVec(12, 0, 0, 'h10, 'h10, 0);
    applyVec(12, 0, 0, 'h0F, 'h10, 1);
    applyVec(12, 1, 0, 'h8000, 'h7FFF, 0);
    // R8 increment/decrement wrap
    applyVec(13, 0, 0, 'h33FF, 0, 0);
    applyVec(14, 1, 0, 'h0000, 0, 0);
    applyVec(13, 1, 0, 'h7FFF, 0, 0);
    // R9 byte swap in both widths
    applyVec(15, 0, 0, 'h0080, 0, 0);
    applyVec(15, 1, 0, 'h8000, 0, 0);
    applyVec(15, 0, 0, 'h1200, 0, 0);
    // Random sweep over all opcodes, widths and flavours
    for (int i = 0; i < 4000; i++) begin
      int rs;
      rs = $urandom;
      applyVec(rs & 15, (rs >> 4) & 1, (rs >> 5) & 1,
               $urandom & 'hFFFF, $urandom & 'hFFFF, (rs >> 6) & 1);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule